// File: doc/BRIEF.md
# UART Control and Interrupt Register Core

This block is the register side of a UART. Software reaches it through 32-bit word writes and combinational reads on a plain register bus. The block stores the configuration of the line: framing, control, two baud divisor parts, an infrared low-power divisor, a queue threshold and a DMA enable field. The character queues, the serializer and the DMA engine sit outside this block. Events from those parts arrive as single-cycle set pulses on `evt_set`. Writes to the data register also raise the transmit interrupt.

The core keeps the raw interrupt status and a mask. It drives six interrupt lines: one combined line, and one line for each of these classes: receive, transmit, receive timeout, modem status and error. In internal loopback, a write to the control register copies the four software modem outputs into the modem-status flags and rebuilds the modem interrupt group from the new flags. The top of the address space holds a read-only identification area of eight bytes, one byte in each word.

Top module: `uart_ctrl_core`

## Requirements
- R1: After reset the threshold register (0x34) reads 0x12 and the flag register (0x18) reads 0x90, meaning both queue-empty flags (bit 4 receive, bit 7 transmit) are set and every modem flag is low. Every other register, including the mask, raw status, both divisors and the DMA field, reads zero.
- R2: The masked status (0x40) equals raw status (0x3C) AND mask (0x38). Writes to 0x3C and 0x40 change nothing.
- R3: Writing the clear register (0x44) clears each raw bit whose written bit is 1, and 0x44 reads zero. An `evt_set` bit that arrives in the same cycle as the clear write wins, so that bit stays set.
- R4: `irq_any` is high when any masked bit is set. `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6. `irq_modem` is the OR of masked bits 3:0, and `irq_err` is the OR of masked bits 10:7. Raw bit order: RI 0, CTS 1, DCD 2, DSR 3, RX 4, TX 5, timeout 6, framing 7, parity 8, break 9, overrun 10.
- R5: Every write to the data register (0x00) sets raw bit 5 (TX) on the same clock edge.
- R6: A write to the control register (0x30) with bit 7 (loopback) set loads the modem flags from the written value. Out2 (bit 13) goes to RI (flag bit 8), Out1 (bit 12) to DCD (flag bit 2), RTS (bit 11) to CTS (flag bit 0) and DTR (bit 10) to DSR (flag bit 1). This also happens on the write that first enables loopback. Control writes with bit 7 clear leave the flags unchanged.
- R7: On such a loopback write, raw bits 3:0 are first cleared and then set for each modem flag that is now high. `evt_set` bits in the same cycle are still ORed in.
- R8: The integer divisor (0x24) keeps 16 bits and the fractional divisor (0x28) keeps 6 bits. Line control (0x2C) and infrared (0x20) keep 8 bits, threshold 6 bits, DMA control (0x48) 3 bits and control 16 bits. Higher written bits read back as zero.
- R9: Word offsets 0xFE0 to 0xFFC return identification byte k (k = (offset − 0xFE0)/4) in bits 7:0. Byte k is bits 8k+7:8k of parameter `ID_BYTES`, which by default gives 0x21, 0x30, 0x04, 0x00, 0xB1, 0x05, 0xF0, 0x0D. The data register and every unmapped offset read zero.
- R10: Writes to the flag register (0x18) change nothing.
- R11: An `evt_set` pulse sets the matching raw bits. Bits 10:7 of the pulse are also captured into receive status (0x04) bits 3:0. Any write to 0x04 clears the receive status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | 12 | Byte address, bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_set | input | 11 | One-cycle raw status set pulses from queue and line logic |
| irq_any | output | 1 | Any masked interrupt |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_rt | output | 1 | Masked receive-timeout interrupt |
| irq_modem | output | 1 | Any masked modem-status interrupt |
| irq_err | output | 1 | Any masked error interrupt |

## Verification
Two functions can act on the raw status in the same clock: an external `evt_set` pulse and a software write that removes bits, either through the clear register or through the rebuild of the modem group on a loopback control write. The bench drives an event pulse in the very cycle of such a write. It then checks that the event bit survives while the other addressed bits go, and the reference model applies the rule "clear first, then set". Every clock, the six interrupt lines are compared against that model.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
  localparam int IRQ_W = 11;
  localparam int WIDX_W = 10;

  localparam logic [WIDX_W-1:0] W_DATA = 10'h000;
  localparam logic [WIDX_W-1:0] W_RSTAT = 10'h001;
  localparam logic [WIDX_W-1:0] W_FLAG = 10'h006;
  localparam logic [WIDX_W-1:0] W_IRDA = 10'h008;
  localparam logic [WIDX_W-1:0] W_IDIV = 10'h009;
  localparam logic [WIDX_W-1:0] W_FDIV = 10'h00A;
  localparam logic [WIDX_W-1:0] W_LINE = 10'h00B;
  localparam logic [WIDX_W-1:0] W_CTRL = 10'h00C;
  localparam logic [WIDX_W-1:0] W_THR = 10'h00D;
  localparam logic [WIDX_W-1:0] W_MASK = 10'h00E;
  localparam logic [WIDX_W-1:0] W_RAW = 10'h00F;
  localparam logic [WIDX_W-1:0] W_MSKD = 10'h010;
  localparam logic [WIDX_W-1:0] W_CLR = 10'h011;
  localparam logic [WIDX_W-1:0] W_DMA = 10'h012;

  // raw status bit positions
  localparam int B_RI = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX = 4;
  localparam int B_TX = 5;
  localparam int B_RT = 6;

  // control register fields
  localparam int C_LOOP = 7;
  localparam int C_DTR = 10;
  localparam int C_RTS = 11;
  localparam int C_OUT1 = 12;
  localparam int C_OUT2 = 13;

  // per-class line masks: rx, tx, timeout, modem, error
  localparam int N_CLASS = 5;
  localparam logic [IRQ_W-1:0] CLASS_MASK [N_CLASS] = '{
    11'h010, 11'h020, 11'h040, 11'h00F, 11'h780
  };

  typedef struct packed {
    logic ri;
    logic dcd;
    logic cts;
    logic dsr;
  } modem_flags_t;
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_core_pkg::*;
#(
  parameter int IDIV_W = 16,
  parameter int FDIV_W = 6,
  parameter int LINE_W = 8,
  parameter int IRDA_W = 8,
  parameter int THR_W = 6,
  parameter int DMA_W = 3,
  parameter int CTRL_W = 16,
  parameter logic [5:0] THR_RST = 6'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] widx,
  input  logic [15:0]       wdata,
  output logic [IDIV_W-1:0] idiv,
  output logic [FDIV_W-1:0] fdiv,
  output logic [LINE_W-1:0] line,
  output logic [IRDA_W-1:0] irda,
  output logic [THR_W-1:0]  thr,
  output logic [DMA_W-1:0]  dma,
  output logic [CTRL_W-1:0] ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idiv <= '0;
      fdiv <= '0;
      line <= '0;
      irda <= '0;
      thr  <= THR_W'(THR_RST);
      dma  <= '0;
      ctrl <= '0;
    end else if (wr_en) begin
      case (widx)
        W_IDIV: idiv <= wdata[IDIV_W-1:0];
        W_FDIV: fdiv <= wdata[FDIV_W-1:0];
        W_LINE: line <= wdata[LINE_W-1:0];
        W_IRDA: irda <= wdata[IRDA_W-1:0];
        W_THR:  thr  <= wdata[THR_W-1:0];
        W_DMA:  dma  <= wdata[DMA_W-1:0];
        W_CTRL: ctrl <= wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  assert_thr_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> thr == THR_W'(THR_RST));
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
  import uart_core_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic [15:0]  wdata,
  output modem_flags_t flags,
  output logic         lb_load,
  output logic [3:0]   lb_bits
);
  modem_flags_t nxt;

  always_comb begin
    nxt.ri  = wdata[C_OUT2];
    nxt.dcd = wdata[C_OUT1];
    nxt.cts = wdata[C_RTS];
    nxt.dsr = wdata[C_DTR];
    lb_load = ctrl_wr && wdata[C_LOOP];
    lb_bits = '0;
    lb_bits[B_RI]  = nxt.ri;
    lb_bits[B_CTS] = nxt.cts;
    lb_bits[B_DCD] = nxt.dcd;
    lb_bits[B_DSR] = nxt.dsr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else if (lb_load) flags <= nxt;
  end

  assert_loop_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[C_LOOP]) |=>
      (flags.ri == $past(wdata[C_OUT2]) && flags.dcd == $past(wdata[C_OUT1]) &&
       flags.cts == $past(wdata[C_RTS]) && flags.dsr == $past(wdata[C_DTR])));

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && wdata[C_LOOP]) |=> $stable(flags));
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt_set,
  input  logic             tx_set,
  input  logic             clr_wr,
  input  logic             mask_wr,
  input  logic             rs_clr,
  input  logic [IRQ_W-1:0] wval,
  input  logic             lb_load,
  input  logic [3:0]       lb_bits,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] masked,
  output logic [3:0]       rstat,
  output logic [N_CLASS-1:0] class_irq,
  output logic             any_irq
);
  logic [IRQ_W-1:0] raw_nxt;

  always_comb begin
    raw_nxt = raw;
    if (clr_wr) raw_nxt = raw_nxt & ~wval;
    if (lb_load) raw_nxt[3:0] = lb_bits;
    raw_nxt = raw_nxt | evt_set;
    if (tx_set) raw_nxt[B_TX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw   <= '0;
      mask  <= '0;
      rstat <= '0;
    end else begin
      raw <= raw_nxt;
      if (mask_wr) mask <= wval;
      rstat <= (rs_clr ? 4'h0 : rstat) | evt_set[IRQ_W-1:IRQ_W-4];
    end
  end

  assign masked = raw & mask;
  assign any_irq = |masked;

  for (genvar k = 0; k < N_CLASS; k++) begin : g_class
    assign class_irq[k] = |(masked & CLASS_MASK[k]);
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (raw & $past(wval & ~evt_set)) == '0);

  assert_evt_sticks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> (raw & $past(evt_set)) == $past(evt_set));

  assert_tx_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> raw[B_TX]);

  assert_modem_rebuild_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_load |=> raw[3:0] == $past(lb_bits | evt_set[3:0]));
endmodule

// File: rtl/uart_rdmux.sv
module uart_rdmux
  import uart_core_pkg::*;
#(
  parameter logic [63:0] ID_BYTES = 64'h0DF005B1_00043021
) (
  input  logic [WIDX_W-1:0] ridx,
  input  logic [3:0]        rstat,
  input  modem_flags_t      flags,
  input  logic [7:0]        irda,
  input  logic [15:0]       idiv,
  input  logic [5:0]        fdiv,
  input  logic [7:0]        line,
  input  logic [15:0]       ctrl,
  input  logic [5:0]        thr,
  input  logic [IRQ_W-1:0]  mask,
  input  logic [IRQ_W-1:0]  raw,
  input  logic [IRQ_W-1:0]  masked,
  input  logic [2:0]        dma,
  output logic [31:0]       rdata
);
  logic [31:0] flag_word;

  always_comb begin
    flag_word = 32'h0;
    flag_word[0] = flags.cts;
    flag_word[1] = flags.dsr;
    flag_word[2] = flags.dcd;
    flag_word[4] = 1'b1;
    flag_word[7] = 1'b1;
    flag_word[8] = flags.ri;
  end

  always_comb begin
    rdata = 32'h0;
    if (ridx[WIDX_W-1:3] == '1) begin
      rdata[7:0] = ID_BYTES[ridx[2:0]*8 +: 8];
    end else begin
      case (ridx)
        W_RSTAT: rdata[3:0]  = rstat;
        W_FLAG:  rdata       = flag_word;
        W_IRDA:  rdata[7:0]  = irda;
        W_IDIV:  rdata[15:0] = idiv;
        W_FDIV:  rdata[5:0]  = fdiv;
        W_LINE:  rdata[7:0]  = line;
        W_CTRL:  rdata[15:0] = ctrl;
        W_THR:   rdata[5:0]  = thr;
        W_MASK:  rdata[IRQ_W-1:0] = mask;
        W_RAW:   rdata[IRQ_W-1:0] = raw;
        W_MSKD:  rdata[IRQ_W-1:0] = masked;
        W_DMA:   rdata[2:0]  = dma;
        default: rdata = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/uart_ctrl_core.sv
module uart_ctrl_core
  import uart_core_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [63:0] ID_BYTES = 64'h0DF005B1_00043021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [IRQ_W-1:0]  evt_set,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rt,
  output logic              irq_modem,
  output logic              irq_err
);
  localparam int IDX_LSB = 2;

  logic [WIDX_W-1:0] widx;
  logic [15:0] idiv, ctrl;
  logic [7:0] line, irda;
  logic [5:0] fdiv, thr;
  logic [2:0] dma;
  logic [IRQ_W-1:0] raw, mask, masked;
  logic [3:0] rstat, lb_bits;
  logic [N_CLASS-1:0] class_irq;
  logic lb_load, any_irq;
  modem_flags_t flags;

  assign widx = addr[IDX_LSB +: WIDX_W];

  uart_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx), .wdata(wdata[15:0]),
    .idiv(idiv), .fdiv(fdiv), .line(line), .irda(irda), .thr(thr),
    .dma(dma), .ctrl(ctrl)
  );

  uart_modem_loop u_loop (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_en && widx == W_CTRL),
    .wdata(wdata[15:0]), .flags(flags), .lb_load(lb_load), .lb_bits(lb_bits)
  );

  uart_irq_core u_irq (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
    .tx_set(wr_en && widx == W_DATA),
    .clr_wr(wr_en && widx == W_CLR),
    .mask_wr(wr_en && widx == W_MASK),
    .rs_clr(wr_en && widx == W_RSTAT),
    .wval(wdata[IRQ_W-1:0]), .lb_load(lb_load), .lb_bits(lb_bits),
    .raw(raw), .mask(mask), .masked(masked), .rstat(rstat),
    .class_irq(class_irq), .any_irq(any_irq)
  );

  uart_rdmux #(.ID_BYTES(ID_BYTES)) u_rd (
    .ridx(widx), .rstat(rstat), .flags(flags), .irda(irda), .idiv(idiv),
    .fdiv(fdiv), .line(line), .ctrl(ctrl), .thr(thr), .mask(mask),
    .raw(raw), .masked(masked), .dma(dma), .rdata(rdata)
  );

  assign irq_rx    = class_irq[0];
  assign irq_tx    = class_irq[1];
  assign irq_rt    = class_irq[2];
  assign irq_modem = class_irq[3];
  assign irq_err   = class_irq[4];
  assign irq_any   = any_irq;

  assert_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_rx | irq_tx | irq_rt | irq_modem | irq_err));

  assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (masked & ~mask) == '0);
endmodule

// File: tb/test_uart_ctrl_core.sv
`timescale 1ns/1ps
module test_uart_ctrl_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [10:0] evt_set = '0;
  logic [31:0] rdata;
  logic irq_any, irq_rx, irq_tx, irq_rt, irq_modem, irq_err;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;

  // behavioural reference state
  int m_raw, m_mask, m_rs, m_ctrl, m_idiv, m_fdiv, m_line, m_irda, m_thr, m_dma;
  bit m_ri, m_dcd, m_cts, m_dsr;

  always #2.5 clk = ~clk;

  uart_ctrl_core i_uart_ctrl_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_set(evt_set), .irq_any(irq_any), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_rt(irq_rt), .irq_modem(irq_modem), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_raw = 0; m_mask = 0; m_rs = 0; m_ctrl = 0; m_idiv = 0; m_fdiv = 0;
    m_line = 0; m_irda = 0; m_thr = 'h12; m_dma = 0;
    m_ri = 0; m_dcd = 0; m_cts = 0; m_dsr = 0;
  endtask

  task automatic model_step(input bit w, input int a, input int d, input int e);
    int mb;
    if (w) begin
      case (a)
        'h00: m_raw |= 'h20;
        'h04: m_rs = 0;
        'h20: m_irda = d & 'hFF;
        'h24: m_idiv = d & 'hFFFF;
        'h28: m_fdiv = d & 'h3F;
        'h2C: m_line = d & 'hFF;
        'h30: begin
          m_ctrl = d & 'hFFFF;
          if (d[7]) begin
            m_ri = d[13]; m_dcd = d[12]; m_cts = d[11]; m_dsr = d[10];
            mb = (m_ri ? 1 : 0) | (m_cts ? 2 : 0) | (m_dcd ? 4 : 0) | (m_dsr ? 8 : 0);
            m_raw = (m_raw & ~'hF) | mb;
          end
        end
        'h34: m_thr = d & 'h3F;
        'h38: m_mask = d & 'h7FF;
        'h44: m_raw &= ~(d & 'h7FF);
        'h48: m_dma = d & 'h7;
        default: ;
      endcase
    end
    m_raw |= e;
    m_rs |= (e >> 7) & 'hF;
  endtask

  function automatic int exp_read(input int a);
    if (a >= 'hFE0 && a <= 'hFFC) begin
      case ((a - 'hFE0) / 4)
        0: return 'h21; 1: return 'h30; 2: return 'h04; 3: return 'h00;
        4: return 'hB1; 5: return 'h05; 6: return 'hF0; default: return 'h0D;
      endcase
    end
    case (a)
      'h04: return m_rs;
      'h18: return 'h90 | (m_cts ? 1 : 0) | (m_dsr ? 2 : 0) | (m_dcd ? 4 : 0) | (m_ri ? 'h100 : 0);
      'h20: return m_irda;
      'h24: return m_idiv;
      'h28: return m_fdiv;
      'h2C: return m_line;
      'h30: return m_ctrl;
      'h34: return m_thr;
      'h38: return m_mask;
      'h3C: return m_raw;
      'h40: return m_raw & m_mask;
      'h48: return m_dma;
      default: return 0;
    endcase
  endfunction

  task automatic op(input bit w, input int a, input int d, input int e);
    @(negedge clk);
    wr_en = w; addr = 12'(a); wdata = d; evt_set = 11'(e);
    @(posedge clk);
    model_step(w, a, d, e);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    wr_en = 0; evt_set = '0; addr = 12'(a);
    #1;
    chk(rdata == 32'(exp_read(a)), tag, rdata, exp_read(a));
  endtask

  task automatic rd_lit(input int a, input int exp, input string tag);
    @(negedge clk);
    wr_en = 0; evt_set = '0; addr = 12'(a);
    #1;
    chk(rdata == 32'(exp), tag, rdata, exp);
  endtask

  // every-clock comparison of the six lines (R4)
  always @(negedge clk) begin
    if (live) begin
      int mk;
      mk = m_raw & m_mask;
      chk(irq_any == (mk != 0), "R4 any", int'(irq_any), int'(mk != 0));
      chk(irq_rx == mk[4], "R4 rx", int'(irq_rx), int'(mk[4]));
      chk(irq_tx == mk[5], "R4 tx", int'(irq_tx), int'(mk[5]));
      chk(irq_rt == mk[6], "R4 rt", int'(irq_rt), int'(mk[6]));
      chk(irq_modem == ((mk & 'hF) != 0), "R4 modem", int'(irq_modem), int'((mk & 'hF) != 0));
      chk(irq_err == ((mk & 'h780) != 0), "R4 err", int'(irq_err), int'((mk & 'h780) != 0));
    end
  end

  initial begin
    #(5ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    live = 1'b1;

    // R1 reset state
    rd_lit('h34, 'h12, "R1 threshold");
    rd_lit('h18, 'h90, "R1 flags");
    rd_lit('h38, 0, "R1 mask");
    rd_lit('h3C, 0, "R1 raw");
    rd_lit('h24, 0, "R1 idiv");
    rd_lit('h48, 0, "R1 dma");

    // R8 widths
    op(1, 'h24, 'hABCD1234, 0); rd_lit('h24, 'h1234, "R8 idiv");
    op(1, 'h28, 'hFF, 0);       rd_lit('h28, 'h3F, "R8 fdiv");
    op(1, 'h2C, 'h1FF, 0);      rd('h2C, "R8 line");
    op(1, 'h20, 'hF5A, 0);      rd('h20, "R8 irda");
    op(1, 'h48, 'hFF, 0);       rd_lit('h48, 'h7, "R8 dma");
    op(1, 'h34, 'hFF, 0);       rd('h34, "R8 thr");

    // R5 data write raises TX
    op(1, 'h38, 'h7FF, 0);
    op(1, 'h00, 'h41, 0);
    rd_lit('h3C, 'h20, "R5 tx raw");
    rd_lit('h00, 0, "R9 data reads zero");

    // R11 events and error capture
    op(0, 0, 0, 'h0D0);
    rd_lit('h3C, 'h0F0, "R11 raw");
    rd_lit('h04, 'h1, "R11 rstat");
    op(1, 'h04, 0, 0);
    rd_lit('h04, 0, "R11 rstat cleared");

    // R3 clear and clear-vs-event collision
    op(1, 'h44, 'h20, 0);
    rd_lit('h3C, 'h0D0, "R3 clear");
    rd_lit('h44, 0, "R3 reads zero");
    op(1, 'h44, 'h0D0, 'h010);
    rd_lit('h3C, 'h010, "R3 event wins");

    // R2 masked status and ignored writes; R10 flags ignored
    op(0, 0, 0, 'h400);
    op(1, 'h38, 'h0F0, 0);
    rd_lit('h40, 'h010, "R2 masked");
    op(1, 'h3C, 'h7FF, 0); rd('h3C, "R2 raw write ignored");
    op(1, 'h40, 'h7FF, 0); rd('h40, "R2 masked write ignored");
    op(1, 'h18, 'hFFFF, 0); rd_lit('h18, 'h90, "R10 flags write ignored");
    op(1, 'h38, 'h7FF, 0);

    // R6 no loopback: flags stay
    op(1, 'h30, 'h3C01, 0);
    rd_lit('h18, 'h90, "R6 no loopback");
    // R6/R7 enable loopback with all four outputs
    op(1, 'h30, 'h3C80, 0);
    rd_lit('h18, 'h197, "R6 loop copy");
    rd('h3C, "R7 modem group set");
    // R7 rebuild with a stale modem bit and coinciding event on DCD
    op(1, 'h30, 'h0880, 'h004);
    rd_lit('h18, 'h91, "R6 only cts");
    rd_lit('h3C, 'h416, "R7 rebuild");

    // R9 identification and unmapped
    for (int k = 0; k < 8; k++) rd('hFE0 + 4 * k, "R9 id");
    rd_lit('h100, 0, "R9 unmapped");
    rd_lit('hFDC, 0, "R9 below id");

    repeat (4) @(negedge clk);
    live = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule